// File: doc/BRIEF.md
# MII Management Frame Register

This block is a host-visible 32-bit command word that performs one management transaction against an on-chip PHY register file each time software writes it. The written word carries a start code, an opcode, a PHY address, a register index and a 16-bit data field. When the start code and PHY address are valid, the block either stores the data field into the addressed PHY register or fetches the register into the data field. In every case it returns the word with its low turnaround bit set, which software uses as the "done" flag.

The PHY register file also models the side effects of the control and status registers. Writing the reset bit of the control register turns into autonegotiation-enable. Writing the restart bit marks negotiation complete and, while the link input is high, reports link up and partner 100BASE-TX full-duplex ability. A second, separate configuration word sits beside the frame register and has two bits that software cannot write. Both words are read through one combinational read port selected by `rd_sel`.

Top module: `mii_mgmt_frame`

## Requirements
- R1: After reset the frame word reads 0 and the configuration word reads 0x00000100. PHY register 1 reads 0x4028, or 0x402C when `link_up` was high during reset. Every other PHY register reads 0.
- R2: A frame write whose start code (bits 31:30) is not 01, or whose PHY address (bits 27:23) is not 1, is stored unchanged except that bit 16 is set. No PHY register changes.
- R3: An accepted frame write with opcode (bits 29:28) 01 stores data bits 15:0 into the PHY register indexed by bits 22:18. The stored frame word is the written word with bit 16 set.
- R4: An accepted frame write with opcode 10 stores the written word with bit 16 set and bits 15:0 replaced by the current contents of the indexed PHY register. Bit 17 keeps its written value.
- R5: An accepted frame write with opcode 00 or 11 changes no PHY register and is stored with bit 16 set.
- R6: A write of data to PHY register 0 stores it with bit 15 cleared. When bit 15 was set, bit 12 is stored set. Writes without bits 15 or 9 store the data unchanged.
- R7: A write to PHY register 0 with bit 9 set stores it with bit 9 cleared and sets bit 5 of PHY register 1.
- R8: On such a restart, if `link_up` is high, bit 2 of PHY register 1 and bit 8 of PHY register 5 are also set. If `link_up` is low, both keep their previous values.
- R9: A configuration write takes every written bit except bits 9:8, which keep their previous values.
- R10: `rd_data` shows the frame word when `rd_sel` is 0 and the configuration word when it is 1. A new frame word is visible after the clock edge that accepts its write. A configuration write leaves the frame word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link state used by reset and autonegotiation restart |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 frame word, 1 configuration word |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 1 | Read source: 0 frame word, 1 configuration word |
| rd_data | output | 32 | Combinational read data |

## Verification
The assertions take for granted that `wr_data` is stable for the whole cycle in which `wr_en` is high. They also assume `link_up` does not change during a cycle in which a restart is written. The bench meets both by changing every input only on the falling clock edge and holding each write strobe for exactly one cycle. It also toggles `link_up` only between transactions.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] ST_VALID = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int TA_DONE_BIT = 16;

  localparam int CTL_IDX     = 0;
  localparam int STS_IDX     = 1;
  localparam int PARTNER_IDX = 5;

  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_ANEN_BIT    = 12;
  localparam int CTL_RESTART_BIT = 9;

  localparam logic [15:0] STS_LINK   = 16'h0004;
  localparam logic [15:0] STS_ANABLE = 16'h0008;
  localparam logic [15:0] STS_ANDONE = 16'h0020;
  localparam logic [15:0] STS_TXFD   = 16'h4000;
  localparam logic [15:0] LPA_TXFD   = 16'h0100;

  localparam logic [15:0] STS_BASE = STS_ANABLE | STS_ANDONE | STS_TXFD;

  // Control word as stored: reset folds into AN enable, restart self-clears.
  function automatic logic [15:0] ctl_fold(input logic [15:0] d);
    logic [15:0] r;
    r = d;
    if (d[CTL_RESET_BIT]) begin
      r[CTL_RESET_BIT] = 1'b0;
      r[CTL_ANEN_BIT]  = 1'b1;
    end
    r[CTL_RESTART_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] sts_after_restart(input logic [15:0] s, input logic lnk);
    return s | STS_ANDONE | (lnk ? STS_LINK : 16'h0000);
  endfunction

  function automatic logic [31:0] ro_merge(input logic [31:0] nv, input logic [31:0] ov,
                                           input logic [31:0] ro_mask);
    return (nv & ~ro_mask) | (ov & ro_mask);
  endfunction
endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode #(
  parameter int PHY_ADDR = 1
) (
  input  logic [13:0] hdr,
  output logic        accept,
  output logic        is_wr,
  output logic        is_rd,
  output logic [4:0]  reg_idx
);
  import mgmt_pkg::*;

  logic [1:0] st_f;
  logic [1:0] op_f;
  logic [4:0] phy_f;

  assign st_f    = hdr[13:12];
  assign op_f    = hdr[11:10];
  assign phy_f   = hdr[9:5];
  assign reg_idx = hdr[4:0];

  assign accept = (st_f == ST_VALID) && (phy_f == 5'(PHY_ADDR));
  assign is_wr  = accept && (op_f == OP_WRITE);
  assign is_rd  = accept && (op_f == OP_READ);
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs #(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          wr_en,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic [15:0]   ctl_word,
  output logic [15:0]   status_word
);
  import mgmt_pkg::*;

  logic [15:0] regs [NREGS];
  logic        ctl_hit;
  logic        restart;

  assign ctl_hit = wr_en && (idx == AW'(CTL_IDX));
  assign restart = ctl_hit && wdata[CTL_RESTART_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      regs[STS_IDX] <= STS_BASE | (link_up ? STS_LINK : 16'h0000);
    end else if (ctl_hit) begin
      regs[CTL_IDX] <= ctl_fold(wdata);
      if (restart) begin
        regs[STS_IDX] <= sts_after_restart(regs[STS_IDX], link_up);
        if (link_up) regs[PARTNER_IDX] <= regs[PARTNER_IDX] | LPA_TXFD;
      end
    end else if (wr_en) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata       = regs[idx];
  assign ctl_word    = regs[CTL_IDX];
  assign status_word = regs[STS_IDX];
endmodule

// File: rtl/mgmt_cfg_reg.sv
module mgmt_cfg_reg #(
  parameter logic [31:0] RO_MASK = 32'h0000_0300,
  parameter logic [31:0] RST_VAL = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  import mgmt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= ro_merge(wdata, q, RO_MASK);
  end
endmodule

// File: rtl/mii_mgmt_frame.sv
module mii_mgmt_frame #(
  parameter int PHY_ADDR = 1,
  parameter int NREGS    = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data
);
  import mgmt_pkg::*;

  logic        dec_accept, dec_wr, dec_rd;
  logic [4:0]  dec_idx;
  logic        frame_wr;
  logic        cmd_accept, cmd_write, cmd_read;
  logic        ctl_write_hit, restart_hit;
  logic [15:0] phy_rdata, ctl_word, status_word;
  logic [31:0] resp_word, frame_q, cfg_q;

  mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .hdr(wr_data[31:18]), .accept(dec_accept), .is_wr(dec_wr),
    .is_rd(dec_rd), .reg_idx(dec_idx)
  );

  assign frame_wr      = wr_en && !wr_sel;
  assign cmd_accept    = frame_wr && dec_accept;
  assign cmd_write     = frame_wr && dec_wr;
  assign cmd_read      = frame_wr && dec_rd;
  assign ctl_write_hit = cmd_write && (dec_idx == 5'(CTL_IDX));
  assign restart_hit   = ctl_write_hit && wr_data[CTL_RESTART_BIT];

  mgmt_phy_regs #(.NREGS(NREGS)) u_phy (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(cmd_write),
    .idx(dec_idx[AW-1:0]), .wdata(wr_data[15:0]), .rdata(phy_rdata),
    .ctl_word(ctl_word), .status_word(status_word)
  );

  mgmt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_sel), .wdata(wr_data), .q(cfg_q)
  );

  always_comb begin
    resp_word = wr_data;
    resp_word[TA_DONE_BIT] = 1'b1;
    if (dec_rd) resp_word[15:0] = phy_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        frame_q <= '0;
    else if (frame_wr) frame_q <= resp_word;
  end

  assign rd_data = rd_sel ? cfg_q : frame_q;
endmodule

// File: rtl/mgmt_frame_checker.sv
module mgmt_frame_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic        cmd_accept,
  input logic        cmd_read,
  input logic        ctl_write_hit,
  input logic        restart_hit,
  input logic [31:0] frame_q,
  input logic [31:0] cfg_q,
  input logic [15:0] ctl_word,
  input logic [15:0] status_word
);
  AST_TA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> frame_q[16]); // R2
  AST_REJECT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && !cmd_accept |=> frame_q == ($past(wr_data) | 32'h0001_0000)); // R2
  AST_READ_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read |=> frame_q[31:17] == $past(wr_data[31:17])); // R4
  AST_CTL_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write_hit |=> !ctl_word[15] && !ctl_word[9]); // R6
  AST_RESET_ANEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write_hit && wr_data[15] |=> ctl_word[12]); // R6
  AST_RESTART_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> status_word[5]); // R7
  AST_RESTART_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit && link_up |=> status_word[2]); // R8
  AST_CFG_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> cfg_q[9:8] == $past(cfg_q[9:8])); // R9
  AST_CFG_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> $stable(frame_q)); // R10
endmodule

bind mii_mgmt_frame mgmt_frame_checker u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .cmd_accept(cmd_accept), .cmd_read(cmd_read),
  .ctl_write_hit(ctl_write_hit), .restart_hit(restart_hit), .frame_q(frame_q),
  .cfg_q(cfg_q), .ctl_word(ctl_word), .status_word(status_word)
);

// File: tb/test_mii_mgmt_frame.sv
module test_mii_mgmt_frame;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mii_mgmt_frame i_mii_mgmt_frame (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] ra,
                                     input logic [1:0] ta, input logic [15:0] d);
    return {st, op, phy, ra, ta, d};
  endfunction

  function automatic logic [15:0] pat(input int r);
    return 16'((r * 2329) ^ 23130);
  endfunction

  task automatic wr(input logic sel, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic phy_wr(input int r, input logic [15:0] d);
    wr(1'b0, mk(2'b01, 2'b01, 5'd1, 5'(r), 2'b00, d));
  endtask

  task automatic phy_rd(input int r, output logic [15:0] d);
    logic [31:0] v;
    wr(1'b0, mk(2'b01, 2'b10, 5'd1, 5'(r), 2'b00, 16'h0000));
    rd(1'b0, v);
    d = v[15:0];
  endtask

  task automatic do_reset(input logic lu);
    @(negedge clk);
    link_up = lu; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, w, keep;
    logic [15:0] d;

    // R1: reset with link up, then with link down
    do_reset(1'b1);
    rd(1'b0, v); check("R1 frame", v, 32'h0);
    rd(1'b1, v); check("R1 cfg", v, 32'h0000_0100);
    phy_rd(1, d); check("R1 status link", {16'h0, d}, 32'h402C);
    phy_rd(0, d); check("R1 control", {16'h0, d}, 32'h0);
    phy_rd(5, d); check("R1 partner", {16'h0, d}, 32'h0);
    do_reset(1'b0);
    phy_rd(1, d); check("R1 status nolink", {16'h0, d}, 32'h4028);

    // R3 write sweep, R4 read-back sweep
    for (int r = 2; r < 32; r++) begin
      phy_wr(r, pat(r));
      rd(1'b0, v);
      check("R3 write echo", v, mk(2'b01, 2'b01, 5'd1, 5'(r), 2'b01, pat(r)));
    end
    for (int r = 2; r < 32; r++) begin
      wr(1'b0, mk(2'b01, 2'b10, 5'd1, 5'(r), 2'b10, 16'hFFFF));
      rd(1'b0, v);
      check("R4 read frame", v, mk(2'b01, 2'b10, 5'd1, 5'(r), 2'b11, pat(r)));
    end

    // R2 reject sweep over all start codes and PHY addresses
    for (int st = 0; st < 4; st++) begin
      for (int ph = 0; ph < 32; ph++) begin
        if (!(st == 1 && ph == 1)) begin
          w = mk(2'(st), 2'b01, 5'(ph), 5'd7, 2'b00, 16'hDEAD ^ 16'(st * 32 + ph));
          wr(1'b0, w);
          rd(1'b0, v);
          check("R2 reject store", v, w | 32'h0001_0000);
          phy_rd(7, d);
          check("R2 no access", {16'h0, d}, {16'h0, pat(7)});
        end
      end
    end

    // R5 no-op opcodes
    w = mk(2'b01, 2'b00, 5'd1, 5'd3, 2'b00, 16'h1234);
    wr(1'b0, w); rd(1'b0, v); check("R5 op00 store", v, w | 32'h0001_0000);
    w = mk(2'b01, 2'b11, 5'd1, 5'd3, 2'b10, 16'h4321);
    wr(1'b0, w); rd(1'b0, v); check("R5 op11 store", v, w | 32'h0001_0000);
    phy_rd(3, d); check("R5 reg unchanged", {16'h0, d}, {16'h0, pat(3)});

    // R6 reset bit folding
    phy_wr(1, 16'h0000);
    phy_wr(0, 16'h8000);
    phy_rd(0, d); check("R6 reset fold", {16'h0, d}, 32'h1000);
    phy_rd(1, d); check("R6 status untouched", {16'h0, d}, 32'h0);

    // R7 / R8 restart with link down
    @(negedge clk); link_up = 1'b0;
    phy_wr(5, 16'h0000);
    phy_wr(0, 16'h0200);
    phy_rd(0, d); check("R7 restart clears", {16'h0, d}, 32'h0);
    phy_rd(1, d); check("R7 an complete", {16'h0, d}, 32'h0020);
    phy_rd(5, d); check("R8 partner nolink", {16'h0, d}, 32'h0);

    // R8 restart with link up, combined with reset bit
    @(negedge clk); link_up = 1'b1;
    phy_wr(1, 16'h0000);
    phy_wr(0, 16'h8200);
    phy_rd(0, d); check("R6 combined", {16'h0, d}, 32'h1000);
    phy_rd(1, d); check("R8 status link", {16'h0, d}, 32'h0024);
    phy_rd(5, d); check("R8 partner link", {16'h0, d}, 32'h0100);
    phy_wr(0, 16'h0140);
    phy_rd(0, d); check("R6 plain control", {16'h0, d}, 32'h0140);

    // R9 configuration read-only bits, R10 frame kept
    rd(1'b0, keep);
    wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); check("R9 cfg ones", v, 32'hFFFF_FDFF);
    wr(1'b1, 32'h0000_0000); rd(1'b1, v); check("R9 cfg zeros", v, 32'h0000_0100);
    wr(1'b1, 32'h0000_0200); rd(1'b1, v); check("R9 cfg bit9", v, 32'h0000_0100);
    rd(1'b0, v); check("R10 frame kept", v, keep);
    w = mk(2'b00, 2'b00, 5'd0, 5'd0, 2'b00, 16'hBEEF);
    wr(1'b0, w); rd(1'b0, v); check("R10 frame visible", v, 32'h0001_BEEF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule